// File: doc/BRIEF.md
# Grouped Falling-Edge Key and Wake-Up Interrupt Unit

This block watches eighteen external pins (ten key inputs and eight wake-up inputs) and turns a high-to-low transition on any of them into an interrupt request. The pins are not reported one by one. They are merged into three fixed groups, and each group raises one shared request that maps to one shared handler vector. Each pin carries its own mask bit. A single global block input holds every request away from the outputs without losing it.

Each pin passes through a two-flop synchronizer. The block then compares consecutive synchronized samples, and a high sample followed by a low sample counts as a falling edge. Detection uses only the pin level, whatever direction the pin driver is configured for. A detected edge on an unmasked pin sets a sticky pending flag for its group. That flag stays set until the group's acknowledge pulse clears it.

Next to the three request lines the block presents a group index and an "any" flag, so the processor can pick the vector directly. Groups are ranked by number, and the lowest-numbered active group wins.

Top module: `grp_fall_irq`

## Requirements
- R1: Pin grouping: key pins 9 and 8 drive group 0 (`grp_req_o[0]`), key pins 7 to 0 drive group 1 (`grp_req_o[1]`), and wake pins 7 to 0 drive group 2 (`grp_req_o[2]`). An edge on one pin raises only its own group's bit.
- R2: A request is set only by a falling edge. A rising edge, or a pin held steadily low or high, leaves the requests unchanged.
- R3: A mask bit of 1 in `key_mask_i` or `wake_mask_i` stops that pin from ever setting its group. A mask bit of 0 lets the pin through.
- R4: The pin reaches the request output after a fixed latency. Drive a pin low before clock edge k and the request first shows after edge k+2, never after edge k+1.
- R5: A group's request stays set across any number of cycles until that group's `grp_ack_i` bit is high at a clock edge. After that edge it reads 0. Acknowledging one group does not touch the others.
- R6: If a new falling edge for a group is detected in the same cycle as that group's acknowledge, the request stays set.
- R7: While `irq_block_i` is 1, all `grp_req_o` bits and `req_any_o` read 0. Edges seen in that time are still recorded, and they appear in the same cycle that `irq_block_i` returns to 0.
- R8: `req_any_o` is the OR of `grp_req_o`. `req_idx_o` is the lowest-numbered group whose request is set, and it is 0 when none is set.
- R9: After reset, with the pins idle high, all requests read 0 and `req_idx_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_pins_i | input | 10 | Key input pin levels |
| key_mask_i | input | 10 | Per-key-pin mask, 1 = masked |
| wake_pins_i | input | 8 | Wake-up pin levels |
| wake_mask_i | input | 8 | Per-wake-pin mask, 1 = masked |
| irq_block_i | input | 1 | Global request block, 1 = hold all requests |
| grp_ack_i | input | 3 | Per-group acknowledge, clears pending at the clock edge |
| grp_req_o | output | 3 | Per-group interrupt request |
| req_any_o | output | 1 | Any group request active |
| req_idx_o | output | 2 | Index of the lowest-numbered active group |

## Verification
All eighteen pins are walked one at a time. This shows that each pin reaches exactly its own group and no other, and it also checks the latency at the cycle before and the cycle of the request. Rising edges, pins held low, and fully or partly masked sets are compared against real falling edges, which separates level sensing and mask leaks from correct edge detection. Further patterns cover an edge landing in the same cycle as its acknowledge, an edge arriving while requests are blocked, and all three groups firing at once. These show apart set-versus-clear priority, hold-through-block behaviour and the index ordering.

// File: rtl/grp_fall_irq_pkg.sv
package grp_fall_irq_pkg;
   localparam int unsigned GRP_N = 3;
   localparam int unsigned IDX_W = $clog2(GRP_N);

   typedef enum logic [IDX_W-1:0] {
      GRP_KEY_HI = 2'd0,
      GRP_KEY_LO = 2'd1,
      GRP_WAKE   = 2'd2
   } grp_id_e;
endpackage

// File: rtl/grp_fall_sync.sv
// Multi-stage synchronizer followed by a falling-edge compare of the
// last synchronized sample against one extra delayed sample.
module grp_fall_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
)(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] fall_o
);
   localparam int unsigned LAST = STAGES;

   // stage 0..STAGES-1 synchronize, stage STAGES holds the previous sample
   logic [LAST:0][W-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_q <= '1;
      end else begin
         stg_q[0] <= pin_i;
         for (int s = 1; s <= int'(LAST); s++) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign fall_o = stg_q[LAST] & ~stg_q[LAST-1];
endmodule

// File: rtl/grp_fall_merge.sv
// Folds per-pin edge strobes into per-group set strobes after masking.
module grp_fall_merge
   import grp_fall_irq_pkg::*;
#(
   parameter int unsigned KEY_W    = 10,
   parameter int unsigned KEY_HI_W = 2,
   parameter int unsigned WAKE_W   = 8
)(
   input  logic [KEY_W-1:0]  key_fall_i,
   input  logic [KEY_W-1:0]  key_mask_i,
   input  logic [WAKE_W-1:0] wake_fall_i,
   input  logic [WAKE_W-1:0] wake_mask_i,
   output logic [GRP_N-1:0]  grp_set_o
);
   localparam int unsigned KEY_LO_W = KEY_W - KEY_HI_W;

   logic [KEY_W-1:0]  key_live;
   logic [WAKE_W-1:0] wake_live;

   assign key_live  = key_fall_i  & ~key_mask_i;
   assign wake_live = wake_fall_i & ~wake_mask_i;

   always_comb begin
      grp_set_o             = '0;
      grp_set_o[GRP_KEY_HI] = |key_live[KEY_W-1:KEY_LO_W];
      grp_set_o[GRP_KEY_LO] = |key_live[KEY_LO_W-1:0];
      grp_set_o[GRP_WAKE]   = |wake_live;
   end
endmodule

// File: rtl/grp_fall_pend.sv
// Sticky per-group pending flags; a set in the same cycle as an
// acknowledge wins.
module grp_fall_pend #(
   parameter int unsigned N = 3
)(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] ack_i,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] pend_q;

   for (genvar g = 0; g < int'(N); g++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q[g] <= 1'b0;
         end else if (set_i[g]) begin
            pend_q[g] <= 1'b1;
         end else if (ack_i[g]) begin
            pend_q[g] <= 1'b0;
         end
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/grp_fall_irq.sv
module grp_fall_irq
   import grp_fall_irq_pkg::*;
#(
   parameter int unsigned KEY_W       = 10,
   parameter int unsigned KEY_HI_W    = 2,
   parameter int unsigned WAKE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [KEY_W-1:0]  key_pins_i,
   input  logic [KEY_W-1:0]  key_mask_i,
   input  logic [WAKE_W-1:0] wake_pins_i,
   input  logic [WAKE_W-1:0] wake_mask_i,
   input  logic              irq_block_i,
   input  logic [GRP_N-1:0]  grp_ack_i,
   output logic [GRP_N-1:0]  grp_req_o,
   output logic              req_any_o,
   output logic [IDX_W-1:0]  req_idx_o
);
   // elaboration-time parameter checks
   initial begin
      if (KEY_HI_W == 0 || KEY_HI_W >= KEY_W)
         $fatal(1, "grp_fall_irq: KEY_HI_W must be in 1..KEY_W-1");
      if (WAKE_W == 0)
         $fatal(1, "grp_fall_irq: WAKE_W must be nonzero");
      if (SYNC_STAGES < 2)
         $fatal(1, "grp_fall_irq: SYNC_STAGES must be at least 2");
   end

   logic [KEY_W-1:0]  key_fall_w;
   logic [WAKE_W-1:0] wake_fall_w;
   logic [GRP_N-1:0]  set_w;
   logic [GRP_N-1:0]  pend_q;

   grp_fall_sync #(.W(KEY_W), .STAGES(SYNC_STAGES)) key_sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (key_pins_i),
      .fall_o (key_fall_w)
   );

   grp_fall_sync #(.W(WAKE_W), .STAGES(SYNC_STAGES)) wake_sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (wake_pins_i),
      .fall_o (wake_fall_w)
   );

   grp_fall_merge #(.KEY_W(KEY_W), .KEY_HI_W(KEY_HI_W), .WAKE_W(WAKE_W)) merge_i (
      .key_fall_i  (key_fall_w),
      .key_mask_i  (key_mask_i),
      .wake_fall_i (wake_fall_w),
      .wake_mask_i (wake_mask_i),
      .grp_set_o   (set_w)
   );

   grp_fall_pend #(.N(GRP_N)) pend_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_w),
      .ack_i  (grp_ack_i),
      .pend_o (pend_q)
   );

   assign grp_req_o = irq_block_i ? '0 : pend_q;
   assign req_any_o = |grp_req_o;

   always_comb begin
      req_idx_o = '0;
      for (int i = int'(GRP_N) - 1; i >= 0; i--) begin
         if (grp_req_o[i]) req_idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/grp_fall_irq_chk.sv
module grp_fall_irq_chk
   import grp_fall_irq_pkg::*;
(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             irq_block_i,
   input logic [GRP_N-1:0] grp_ack_i,
   input logic [GRP_N-1:0] grp_req_o,
   input logic             req_any_o,
   input logic [IDX_W-1:0] req_idx_o,
   input logic [GRP_N-1:0] set_w,
   input logic [GRP_N-1:0] pend_q
);
   AST_BLOCK_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_block_i |-> (grp_req_o == '0) && !req_any_o); // R7

   AST_IDX_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_any_o |-> grp_req_o[req_idx_o]); // R8

   AST_IDX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_any_o |-> ((grp_req_o & ((GRP_N'(1) << req_idx_o) - GRP_N'(1))) == '0)); // R8

   for (genvar g = 0; g < int'(GRP_N); g++) begin : g_grp
      AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (grp_ack_i[g] && !set_w[g]) |=> !pend_q[g]); // R5

      AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (pend_q[g] && !grp_ack_i[g]) |=> pend_q[g]); // R5

      AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_w[g] |=> pend_q[g]); // R6

      AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!pend_q[g] && !set_w[g]) |=> !pend_q[g]); // R2
   end
endmodule

bind grp_fall_irq grp_fall_irq_chk chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .irq_block_i (irq_block_i),
   .grp_ack_i   (grp_ack_i),
   .grp_req_o   (grp_req_o),
   .req_any_o   (req_any_o),
   .req_idx_o   (req_idx_o),
   .set_w       (set_w),
   .pend_q      (pend_q)
);

// File: tb/grp_fall_irq_tb_top.sv
module grp_fall_irq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] key_pins = '1;
   logic [9:0] key_mask = '0;
   logic [7:0] wake_pins = '1;
   logic [7:0] wake_mask = '0;
   logic       blk = 1'b0;
   logic [2:0] ack = '0;
   logic [2:0] req;
   logic       any;
   logic [1:0] idx;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;  // 50 MHz

   grp_fall_irq dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .key_pins_i  (key_pins),
      .key_mask_i  (key_mask),
      .wake_pins_i (wake_pins),
      .wake_mask_i (wake_mask),
      .irq_block_i (blk),
      .grp_ack_i   (ack),
      .grp_req_o   (req),
      .req_any_o   (any),
      .req_idx_o   (idx)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pin(input int p, input logic v);
      if (p < 10) key_pins[p] = v;
      else        wake_pins[p-10] = v;
   endtask

   function automatic int grp_of(input int p);
      if (p >= 10)     return 2;
      else if (p >= 8) return 0;
      else             return 1;
   endfunction

   task automatic pulse_ack(input logic [2:0] m);
      ack = m;
      wait_n(1);
      ack = '0;
   endtask

   task automatic t_reset();
      chk("R9 req after reset", 32'(req), 32'h0);
      chk("R9 idx after reset", 32'(idx), 32'h0);
      chk("R9 any after reset", 32'(any), 32'h0);
   endtask

   task automatic t_walk();
      for (int p = 0; p < 18; p++) begin
         logic [2:0] e;
         e = 3'b1 << grp_of(p);
         set_pin(p, 1'b0);
         wait_n(2);
         chk($sformatf("R4 pin %0d early", p), 32'(req), 32'h0);
         wait_n(1);
         chk($sformatf("R1 pin %0d group", p), 32'(req), 32'(e));
         chk($sformatf("R8 pin %0d idx", p), 32'(idx), 32'(grp_of(p)));
         set_pin(p, 1'b1);
         pulse_ack(e);
         chk($sformatf("R5 pin %0d ack", p), 32'(req), 32'h0);
         wait_n(3);
         chk($sformatf("R2 pin %0d rise", p), 32'(req), 32'h0);
      end
   endtask

   task automatic t_steady_and_hold();
      key_pins[3] = 1'b0;
      wait_n(3);
      chk("R1 key3", 32'(req), 32'h2);
      wait_n(6);
      chk("R5 held without ack", 32'(req), 32'h2);
      pulse_ack(3'b101);
      chk("R5 other-group ack", 32'(req), 32'h2);
      pulse_ack(3'b010);
      wait_n(5);
      chk("R2 steady low", 32'(req), 32'h0);
      key_pins[3] = 1'b1;
      wait_n(4);
      chk("R2 release rise", 32'(req), 32'h0);
   endtask

   task automatic t_mask();
      key_mask = '1; wake_mask = '1;
      key_pins = '0; wake_pins = '0;
      wait_n(5);
      chk("R3 all masked", 32'(req), 32'h0);
      key_pins = '1; wake_pins = '1;
      wait_n(4);
      key_mask = 10'h200; wake_mask = 8'h00;
      key_pins[9] = 1'b0;
      wait_n(4);
      chk("R3 key9 masked", 32'(req), 32'h0);
      key_pins[8] = 1'b0;
      wait_n(3);
      chk("R3 key8 unmasked", 32'(req), 32'h1);
      key_pins = '1; key_mask = '0;
      pulse_ack(3'b001);
      wait_n(4);
      chk("R3 cleanup", 32'(req), 32'h0);
   endtask

   task automatic t_block();
      blk = 1'b1;
      wake_pins[0] = 1'b0;
      wait_n(5);
      chk("R7 blocked req", 32'(req), 32'h0);
      chk("R7 blocked any", 32'(any), 32'h0);
      blk = 1'b0;
      #1;
      chk("R7 release shows", 32'(req), 32'h4);
      chk("R8 release idx", 32'(idx), 32'h2);
      wake_pins[0] = 1'b1;
      wait_n(1);
      pulse_ack(3'b100);
      chk("R5 ack after block", 32'(req), 32'h0);
   endtask

   task automatic t_collide();
      key_pins[0] = 1'b0;
      wait_n(3);
      chk("R1 key0", 32'(req), 32'h2);
      key_pins[0] = 1'b1;
      wait_n(3);
      key_pins[1] = 1'b0;
      wait_n(2);
      ack = 3'b010;
      wait_n(1);
      ack = '0;
      chk("R6 edge with ack", 32'(req), 32'h2);
      key_pins[1] = 1'b1;
      pulse_ack(3'b010);
      chk("R5 ack after collide", 32'(req), 32'h0);
      wait_n(3);
   endtask

   task automatic t_prio();
      key_pins[9] = 1'b0; key_pins[5] = 1'b0; wake_pins[3] = 1'b0;
      wait_n(3);
      chk("R1 all groups", 32'(req), 32'h7);
      chk("R8 idx 0", 32'(idx), 32'h0);
      key_pins = '1; wake_pins = '1;
      pulse_ack(3'b001);
      chk("R8 idx 1", 32'(idx), 32'h1);
      pulse_ack(3'b010);
      chk("R8 idx 2", 32'(idx), 32'h2);
      chk("R8 any set", 32'(any), 32'h1);
      pulse_ack(3'b100);
      chk("R8 idx none", 32'(idx), 32'h0);
      chk("R8 any clear", 32'(any), 32'h0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_walk();
      t_steady_and_hold();
      t_mask();
      t_block();
      t_collide();
      t_prio();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule